// File: doc/BRIEF.md
# Printer Port Register Block

This block puts a parallel printer connector behind four byte-wide registers on a small processor bus. Software writes a byte to the data register to place it on the eight printer data pins, drives the strobe, line-feed, reset and select lines and an indicator LED through the control register, and reads the printer's acknowledge, busy, paper-out, selected and error lines through the status register. A fourth register holds a mode word that decides, for each port group, whether the block drives its pins or leaves them released.

The pin-level handshake (strobe width, waiting on busy) belongs to a separate sequencer or to software; this block only decodes, latches and samples. Every status and data input passes through a two-flop synchroniser before a read can see it. Whenever the data group is set to drive, reading offset 0 returns the byte last written, so a write-then-read of a test pattern shows whether the port is fitted.

Top module: `prn_port_regs`

## Requirements
- R1: Offset 0 is the data register. While the data group drives, a write there appears on `pd_out` after the write edge, and a read of offset 0 returns that byte.
- R2: A read of offset 1 (status) returns acknowledge_n in bit 0, busy in bit 1, paper-out in bit 2, selected in bit 3 and error_n in bit 4, taken from `stat_in[4:0]` in that order. Bits 7 to 5 read as zero.
- R3: A status pin change is visible to a read only after two clock edges have passed through the synchroniser. A read whose sampling edge is the second edge after the change still returns the old value.
- R4: A write to offset 2 (control) drives `ctl_n_out[0]` strobe_n from bit 0, `ctl_n_out[1]` linefeed_n from bit 1, `ctl_n_out[2]` reset_n from bit 2, `ctl_n_out[3]` select_n from bit 3 and `led_out` from bit 7, each pin level equal to its written bit. A read of offset 2 returns the written value ANDed with 0x8F.
- R5: A write to offset 3 with bit 7 set loads the mode word, which offset 3 reads back. In that word, bit 4 set makes the data group an input, bit 1 set makes the status port an input, bit 0 set makes the control low nibble an input and bit 3 set makes the LED bit an input. Each output enable (`pd_oe`, `ctl_oe`, `led_oe`) is high exactly when its group is an output. For example, 0x82 gives data and control as outputs and status as an input.
- R6: A write to offset 3 with bit 7 clear changes neither the mode word nor any output.
- R7: A mode word load clears the data and control latches to zero.
- R8: While the data group is an input, `pd_oe` is low and reads of offset 0 return the synchronised `pd_in`.
- R9: While the status port is not an input (mode bit 1 clear), reads of offset 1 return zero.
- R10: Writes to offset 1 change no output and no register.
- R11: After reset the mode word is 0x9B, all enables are low, both latches are zero and `bus_rdata` is zero.
- R12: `bus_rdata` is updated on the clock edge that samples `bus_rd` and holds its value while `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register offset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pd_out | output | 8 | Printer data pins, driven value |
| pd_oe | output | 1 | Data pin output enable |
| pd_in | input | 8 | Printer data pins, sensed value |
| ctl_n_out | output | 4 | Active-low strobe, linefeed, reset, select |
| ctl_oe | output | 1 | Control pin output enable |
| led_out | output | 1 | Indicator LED |
| led_oe | output | 1 | LED output enable |
| stat_in | input | 5 | Printer status pins |

## Verification
The assertions take for granted that `bus_rd` and `bus_wr` are never high in the same cycle, and that each strobe lasts exactly one cycle with address and write data steady across it. The bench drives every access through one task, which raises a single strobe for one clock and drops it, and it changes `stat_in` and `pd_in` only between accesses. The data and control registers are swept over all 256 values, the status pins over all 32 patterns, and the mode word over all 16 combinations of its direction bits.

// File: rtl/prn_port_pkg.sv
package prn_port_pkg;
  localparam int REG_ADDR_W = 2;

  typedef enum logic [REG_ADDR_W-1:0] {
    REG_DATA = 2'd0,
    REG_STAT = 2'd1,
    REG_CTRL = 2'd2,
    REG_MODE = 2'd3
  } reg_sel_e;

  // mode word bit positions
  localparam int MODE_ACCEPT_BIT   = 7;
  localparam int MODE_DATA_IN_BIT  = 4;
  localparam int MODE_CTLHI_IN_BIT = 3;
  localparam int MODE_STAT_IN_BIT  = 1;
  localparam int MODE_CTLLO_IN_BIT = 0;

  localparam logic [7:0] MODE_RESET     = 8'h9B;
  localparam logic [7:0] CTRL_READ_MASK = 8'h8F;
endpackage

// File: rtl/prn_sync.sv
module prn_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= '0;
      else     stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

  // the visible value is the first stage one edge later
  AST_SYNC_TWO_STAGE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (q == $past(stg[STAGES-2]))); // R3
endmodule

// File: rtl/prn_mode_cfg.sv
module prn_mode_cfg
  import prn_port_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mode_q,
  output logic         load,
  output logic         data_is_in,
  output logic         stat_is_in,
  output logic         ctl_lo_is_in,
  output logic         ctl_hi_is_in
);
  assign load = wr_en && wdata[MODE_ACCEPT_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q       <= MODE_RESET;
      data_is_in   <= MODE_RESET[MODE_DATA_IN_BIT];
      stat_is_in   <= MODE_RESET[MODE_STAT_IN_BIT];
      ctl_lo_is_in <= MODE_RESET[MODE_CTLLO_IN_BIT];
      ctl_hi_is_in <= MODE_RESET[MODE_CTLHI_IN_BIT];
    end else if (load) begin
      mode_q       <= wdata;
      data_is_in   <= wdata[MODE_DATA_IN_BIT];
      stat_is_in   <= wdata[MODE_STAT_IN_BIT];
      ctl_lo_is_in <= wdata[MODE_CTLLO_IN_BIT];
      ctl_hi_is_in <= wdata[MODE_CTLHI_IN_BIT];
    end
  end

  AST_MODE_IGNORE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wdata[MODE_ACCEPT_BIT]) |=> $stable(mode_q)); // R6
endmodule

// File: rtl/prn_out_latch.sv
module prn_out_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || clr) q <= '0;
    else if (ld)    q <= d;
  end
endmodule

// File: rtl/prn_port_regs.sv
module prn_port_regs
  import prn_port_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int STAT_W      = 5,
  parameter int CTL_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [REG_ADDR_W-1:0] bus_addr,
  input  logic                  bus_rd,
  input  logic                  bus_wr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  output logic [DATA_W-1:0]     pd_out,
  output logic                  pd_oe,
  input  logic [DATA_W-1:0]     pd_in,
  output logic [CTL_W-1:0]      ctl_n_out,
  output logic                  ctl_oe,
  output logic                  led_out,
  output logic                  led_oe,
  input  logic [STAT_W-1:0]     stat_in
);
  localparam int STAT_PAD = DATA_W - STAT_W;
  localparam int LED_BIT  = DATA_W - 1;

  logic              wr_data, wr_ctrl, wr_mode;
  logic              mode_load;
  logic [DATA_W-1:0] mode_q, data_q, ctrl_q;
  logic [DATA_W-1:0] pd_sync;
  logic [STAT_W-1:0] stat_sync;
  logic              data_is_in, stat_is_in, ctl_lo_is_in, ctl_hi_is_in;
  logic [DATA_W-1:0] rd_mux;

  assign wr_data = bus_wr && (bus_addr == REG_DATA);
  assign wr_ctrl = bus_wr && (bus_addr == REG_CTRL);
  assign wr_mode = bus_wr && (bus_addr == REG_MODE);

  prn_mode_cfg #(.W(DATA_W)) u_mode (
    .clk(clk), .rst(rst), .wr_en(wr_mode), .wdata(bus_wdata),
    .mode_q(mode_q), .load(mode_load),
    .data_is_in(data_is_in), .stat_is_in(stat_is_in),
    .ctl_lo_is_in(ctl_lo_is_in), .ctl_hi_is_in(ctl_hi_is_in)
  );

  prn_out_latch #(.W(DATA_W)) u_data (
    .clk(clk), .rst(rst), .clr(mode_load), .ld(wr_data),
    .d(bus_wdata), .q(data_q)
  );

  prn_out_latch #(.W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst), .clr(mode_load), .ld(wr_ctrl),
    .d(bus_wdata), .q(ctrl_q)
  );

  prn_sync #(.W(STAT_W), .STAGES(SYNC_STAGES)) u_stat_sync (
    .clk(clk), .rst(rst), .d(stat_in), .q(stat_sync)
  );

  prn_sync #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_pd_sync (
    .clk(clk), .rst(rst), .d(pd_in), .q(pd_sync)
  );

  // pins come straight from flops
  assign pd_out    = data_q;
  assign pd_oe     = !data_is_in;
  assign ctl_n_out = ctrl_q[CTL_W-1:0];
  assign ctl_oe    = !ctl_lo_is_in;
  assign led_out   = ctrl_q[LED_BIT];
  assign led_oe    = !ctl_hi_is_in;

  always_comb begin
    unique case (reg_sel_e'(bus_addr))
      REG_DATA: rd_mux = data_is_in ? pd_sync : data_q;
      REG_STAT: rd_mux = stat_is_in ? {{STAT_PAD{1'b0}}, stat_sync} : '0;
      REG_CTRL: rd_mux = ctrl_q & CTRL_READ_MASK;
      default:  rd_mux = mode_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  AST_DATA_LOAD: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == REG_DATA) |=> (pd_out == $past(bus_wdata))); // R1

  AST_STAT_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == REG_STAT) |=> (bus_rdata[DATA_W-1:STAT_W] == '0)); // R2

  AST_DIR_FOLLOWS_MODE: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == REG_MODE && bus_wdata[MODE_ACCEPT_BIT])
    |=> (pd_oe == !$past(bus_wdata[MODE_DATA_IN_BIT]))); // R5

  AST_MODE_CLEARS_LATCH: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == REG_MODE && bus_wdata[MODE_ACCEPT_BIT])
    |=> (pd_out == '0 && ctl_n_out == '0 && !led_out)); // R7

  AST_STATUS_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == REG_STAT)
    |=> ($stable(pd_out) && $stable(ctl_n_out) && $stable(led_out) && $stable(pd_oe))); // R10

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata)); // R12
endmodule

// File: tb/tb_prn_port_regs.sv
module tb_prn_port_regs;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] bus_addr = '0;
  logic       bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] pd_out;
  logic       pd_oe;
  logic [7:0] pd_in = '0;
  logic [3:0] ctl_n_out;
  logic       ctl_oe, led_out, led_oe;
  logic [4:0] stat_in = '0;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  prn_port_regs dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pd_out(pd_out), .pd_oe(pd_oe),
    .pd_in(pd_in), .ctl_n_out(ctl_n_out), .ctl_oe(ctl_oe), .led_out(led_out),
    .led_oe(led_oe), .stat_in(stat_in)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin : watchdog
    #(4 * 200000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] r, held;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R11 reset state
    chk("R11 rdata", bus_rdata, 8'h00);
    chk("R11 enables", {5'd0, pd_oe, ctl_oe, led_oe}, 8'h00);
    chk("R11 pd_out", pd_out, 8'h00);
    chk("R11 ctl", {3'd0, led_out, ctl_n_out}, 8'h00);
    rd(2'd3, r); chk("R11 mode", r, 8'h9B);

    // R8 data group input after reset
    pd_in = 8'h3C; idle(3);
    rd(2'd0, r); chk("R8 data read input", r, 8'h3C);
    chk("R8 pd_oe low", {7'd0, pd_oe}, 8'h00);

    // R5 mode 0x80 all outputs
    wr(2'd3, 8'h80);
    chk("R5 0x80 enables", {5'd0, pd_oe, ctl_oe, led_oe}, 8'h07);
    rd(2'd3, r); chk("R5 0x80 readback", r, 8'h80);

    // R1 sweep of data register
    for (int v = 0; v < 256; v++) begin
      wr(2'd0, 8'(v));
      chk("R1 pd_out", pd_out, 8'(v));
      rd(2'd0, r); chk("R1 readback", r, 8'(v));
    end

    // R9 status not an input
    stat_in = 5'h1F; idle(3);
    rd(2'd1, r); chk("R9 status output mode", r, 8'h00);

    // R5 mode 0x82, R7 latch clear
    wr(2'd2, 8'h81);
    wr(2'd3, 8'h82);
    chk("R7 pd_out cleared", pd_out, 8'h00);
    chk("R7 ctl cleared", {3'd0, led_out, ctl_n_out}, 8'h00);
    rd(2'd0, r); chk("R7 data read cleared", r, 8'h00);
    chk("R5 0x82 enables", {5'd0, pd_oe, ctl_oe, led_oe}, 8'h07);

    // R2 status sweep
    for (int s = 0; s < 32; s++) begin
      stat_in = 5'(s); idle(3);
      rd(2'd1, r); chk("R2 status", r, 8'(s));
    end

    // R3 synchroniser depth
    stat_in = 5'h0A; idle(3);
    rd(2'd1, r);
    @(negedge clk);
    stat_in = 5'h15;
    rd(2'd1, r); chk("R3 old value", r, 8'h0A);
    rd(2'd1, r); chk("R3 new value", r, 8'h15);

    // R4 control sweep
    for (int v = 0; v < 256; v++) begin
      wr(2'd2, 8'(v));
      chk("R4 pins", {3'd0, led_out, ctl_n_out}, {3'd0, 1'(v >> 7), 4'(v)});
      rd(2'd2, r); chk("R4 readback", r, 8'(v) & 8'h8F);
    end
    wr(2'd2, 8'h05);
    chk("R4 0x05 pins", {3'd0, led_out, ctl_n_out}, 8'h05);

    // R10 writes to status ignored
    wr(2'd0, 8'h5A);
    wr(2'd1, 8'hFF);
    chk("R10 pd_out", pd_out, 8'h5A);
    chk("R10 ctl", {3'd0, led_out, ctl_n_out}, 8'h05);
    rd(2'd1, r); chk("R10 status", r, 8'h15);
    rd(2'd3, r); chk("R10 mode", r, 8'h82);

    // R6 mode write with bit 7 clear ignored
    wr(2'd3, 8'h12);
    rd(2'd3, r); chk("R6 mode kept", r, 8'h82);
    chk("R6 pd_out kept", pd_out, 8'h5A);
    chk("R6 enables kept", {5'd0, pd_oe, ctl_oe, led_oe}, 8'h07);

    // R12 rdata holds without read
    rd(2'd0, held);
    stat_in = 5'h03; pd_in = 8'hC3;
    wr(2'd0, 8'h11);
    idle(4);
    chk("R12 hold", bus_rdata, held);

    // R5 / R8 sweep of direction bits
    for (int m = 0; m < 16; m++) begin
      logic [7:0] mw;
      mw = 8'h80 | (8'(m >> 3) << 4) | (8'((m >> 2) & 1) << 3)
                 | (8'((m >> 1) & 1) << 1) | 8'(m & 1);
      wr(2'd3, mw);
      chk("R5 pd_oe",  {7'd0, pd_oe},  {7'd0, ~mw[4]});
      chk("R5 led_oe", {7'd0, led_oe}, {7'd0, ~mw[3]});
      chk("R5 ctl_oe", {7'd0, ctl_oe}, {7'd0, ~mw[0]});
      rd(2'd3, r); chk("R5 mode readback", r, mw);
      rd(2'd0, r); chk("R8 data read", r, mw[4] ? 8'hC3 : 8'h00);
      rd(2'd1, r); chk("R9 status read", r, mw[1] ? 8'h03 : 8'h00);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule